// File: doc/BRIEF.md
# Trimmable Sine Generator

The block synthesises a digital sinusoid. A 32-bit phase register moves forward by a programmable step on every enabled clock, and the step alone sets the output frequency. Before the table lookup, a separate 32-bit offset is added to the phase. The offset covers one full turn over its range, so the offset moves the waveform in phase without changing its rate.

The table value is then multiplied by a signed gain with 14 fraction bits. This trims the amplitude, and a negative gain flips the waveform. Each enabled cycle gives exactly one signed 16-bit sample, flagged valid, a fixed three cycles later. The offset and gain that apply to a sample are the ones present on the same cycle as its enable.

Top module: `dds_trim`

## Requirements
- R1: After reset the phase register is zero. On every clock edge where `en_i` is high it becomes (phase + `phase_inc_i`) mod 2^32. While `en_i` is low it keeps its value.
- R2: The table address for a sample is bits [31:20] of (phase before the step + `phase_ofs_i`) mod 2^32. The value of `phase_ofs_i` taken is the one sampled with `en_i`.
- R3: For address a, let h = a mod 2048 and d = h if h <= 1024, else 2048 - h. Then f = floor(32752*d*(2048-d) / (20971520 - 4*d*(2048-d))). The table value T is f when a < 2048 and -f otherwise. So address 1024 gives 2047, address 3072 gives -2047, and addresses 0 and 2048 give 0.
- R4: The output is floor(T * G / 16384), clamped to [-32768, 32767]. Here G is `gain_i` read as a 16-bit two's-complement number with 14 fraction bits, sampled with `en_i`. Rounding is toward minus infinity, so -2047 times 0x2000 gives -1024.
- R5: A gain of 0x4000 (+1.0) outputs T unchanged. A gain of 0xC000 (-1.0) outputs -T.
- R6: When `en_i` is high at a rising edge, `valid_o` is high for exactly one cycle after the third rising edge, counting that edge as the first. Enables on consecutive cycles give samples on consecutive cycles, in the same order.
- R7: While `valid_o` is low, `sample_o` keeps its last value, whatever happens on the other inputs.
- R8: While `rst_ni` is low, and on the first cycle after it is released, `valid_o` is 0 and `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance the phase and launch one sample |
| phase_inc_i | input | 32 | Phase step per enabled cycle (frequency) |
| phase_ofs_i | input | 32 | Phase offset, full range equals one turn |
| gain_i | input | 16 | Signed amplitude factor with 14 fraction bits |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | Marks `sample_o` as a new sample |

## Verification
Every sample falls due on the third rising edge after the edge that sampled its enable. The bench drives inputs on falling edges and reads outputs on falling edges. A sample launched at one falling edge is therefore looked for at the third falling edge after it, and `valid_o` is checked to be low at the first, second and fourth. A reference queue, filled when each enable is driven, pairs each valid output with its launch in order. This tests back-to-back enables, gaps between them, and per-cycle changes of offset and gain. During idle cycles the output is sampled again to confirm it holds.

// File: rtl/dds_trim_pkg.sv
package dds_trim_pkg;

  // Half-wave sine magnitude from a rational approximation: index idx out of
  // half_len steps per half period, peak value amp at idx = half_len/2.
  function automatic int half_wave_val(int idx, int half_len, int amp);
    longint u;
    longint num;
    longint den;
    u   = longint'(idx) * longint'(half_len - idx);
    num = longint'(amp) * 16 * u;
    den = 5 * longint'(half_len) * longint'(half_len) - 4 * u;
    return int'(num / den);
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int GAIN_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  inc_i,
  input  logic [ACC_W-1:0]  ofs_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              v_o
);
  localparam int DROP = ACC_W - ADDR_W;

  logic [ACC_W-1:0]  acc_q;
  logic [ADDR_W-1:0] addr_d;

  // Offset added to the pre-step phase; only the top bits form the address.
  assign addr_d = ADDR_W'((acc_q + ofs_i) >> DROP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      addr_o <= '0;
      gain_o <= '0;
      v_o    <= 1'b0;
    end else begin
      v_o <= en_i;
      if (en_i) begin
        acc_q  <= acc_q + inc_i;
        addr_o <= addr_d;
        gain_o <= gain_i;
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 12,
  parameter int GAIN_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     v_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic signed [SAMP_W-1:0] samp_o,
  output logic [GAIN_W-1:0]        gain_o,
  output logic                     v_o
);
  localparam int HALF = 2 ** (ADDR_W - 1);
  localparam int QTR  = 2 ** (ADDR_W - 2);
  localparam int AMP  = 2 ** (SAMP_W - 1) - 1;

  logic [SAMP_W-1:0] rom [0:QTR];

  for (genvar g = 0; g <= QTR; g++) begin : g_rom
    assign rom[g] = SAMP_W'(dds_trim_pkg::half_wave_val(g, HALF, AMP));
  end

  logic [ADDR_W-2:0]        half_pos;
  logic [ADDR_W-2:0]        fold_idx;
  logic                     neg_half;
  logic [SAMP_W-1:0]        mag;
  logic signed [SAMP_W-1:0] val_d;

  assign half_pos = addr_i[ADDR_W-2:0];
  assign neg_half = addr_i[ADDR_W-1];
  // HALF - pos equals the two's complement of pos in ADDR_W-1 bits.
  assign fold_idx = (half_pos <= (ADDR_W-1)'(QTR)) ? half_pos : -half_pos;
  assign mag      = rom[fold_idx];
  assign val_d    = neg_half ? -$signed(mag) : $signed(mag);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_o <= '0;
      gain_o <= '0;
      v_o    <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) begin
        samp_o <= val_d;
        gain_o <= gain_i;
      end
    end
  end
endmodule

// File: rtl/dds_gain_stage.sv
module dds_gain_stage #(
  parameter int SAMP_W = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int OUT_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     v_i,
  input  logic signed [SAMP_W-1:0] samp_i,
  input  logic [GAIN_W-1:0]        gain_i,
  output logic signed [OUT_W-1:0]  y_o,
  output logic                     v_o
);
  localparam int PROD_W = SAMP_W + GAIN_W;
  localparam logic signed [PROD_W-1:0] POS_LIM = PROD_W'(2 ** (OUT_W - 1) - 1);
  localparam logic signed [PROD_W-1:0] NEG_LIM = -POS_LIM - 1;

  function automatic logic signed [OUT_W-1:0] clamp(logic signed [PROD_W-1:0] x);
    if (x > POS_LIM)      return OUT_W'(POS_LIM);
    else if (x < NEG_LIM) return OUT_W'(NEG_LIM);
    else                  return OUT_W'(x);
  endfunction

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] scaled;

  assign prod = $signed({{GAIN_W{samp_i[SAMP_W-1]}}, samp_i})
              * $signed({{SAMP_W{gain_i[GAIN_W-1]}}, gain_i});
  assign scaled = prod >>> FRAC;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o <= '0;
      v_o <= 1'b0;
    end else begin
      v_o <= v_i;
      if (v_i) y_o <= clamp(scaled);
    end
  end
endmodule

// File: rtl/dds_trim.sv
module dds_trim #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int SAMP_W = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int OUT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  phase_inc_i,
  input  logic [ACC_W-1:0]  phase_ofs_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic [OUT_W-1:0]  sample_o,
  output logic              valid_o
);
  // Named inter-stage events, visible to the bound checker.
  logic [ACC_W-1:0]         acc_now;
  logic [ADDR_W-1:0]        s1_addr;
  logic [GAIN_W-1:0]        s1_gain;
  logic                     s1_v;
  logic signed [SAMP_W-1:0] s2_samp;
  logic [GAIN_W-1:0]        s2_gain;
  logic                     s2_v;
  logic signed [OUT_W-1:0]  s3_y;

  dds_phase_acc #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .GAIN_W(GAIN_W)) i_acc (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i),
    .inc_i (phase_inc_i), .ofs_i (phase_ofs_i), .gain_i (gain_i),
    .acc_o (acc_now), .addr_o (s1_addr), .gain_o (s1_gain), .v_o (s1_v)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) i_rom (
    .clk_i (clk_i), .rst_ni (rst_ni), .v_i (s1_v),
    .addr_i (s1_addr), .gain_i (s1_gain),
    .samp_o (s2_samp), .gain_o (s2_gain), .v_o (s2_v)
  );

  dds_gain_stage #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)) i_gain (
    .clk_i (clk_i), .rst_ni (rst_ni), .v_i (s2_v),
    .samp_i (s2_samp), .gain_i (s2_gain),
    .y_o (s3_y), .v_o (valid_o)
  );

  assign sample_o = s3_y;
endmodule

// File: rtl/dds_trim_chk.sv
module dds_trim_chk #(
  parameter int ACC_W  = 32,
  parameter int SAMP_W = 12,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int OUT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [ACC_W-1:0]  inc_i,
  input logic [ACC_W-1:0]  acc_i,
  input logic              v1_i,
  input logic              v2_i,
  input logic [SAMP_W-1:0] samp2_i,
  input logic [GAIN_W-1:0] gain2_i,
  input logic              valid_i,
  input logic [OUT_W-1:0]  sample_i
);
  localparam logic [GAIN_W-1:0] G_ONE  = GAIN_W'(2 ** FRAC);
  localparam logic [GAIN_W-1:0] G_MONE = GAIN_W'(-(2 ** FRAC));

  logic [OUT_W-1:0] samp2_ext;
  assign samp2_ext = {{(OUT_W-SAMP_W){samp2_i[SAMP_W-1]}}, samp2_i};

  assert_acc_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> acc_i == $past(acc_i) + $past(inc_i));
  assert_acc_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> acc_i == $past(acc_i));
  assert_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> v1_i);
  assert_no_launch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !v1_i);
  assert_out_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v2_i |=> valid_i);
  assert_out_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v2_i |=> !valid_i);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v2_i |=> $stable(sample_i));
  assert_unity_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v2_i && gain2_i == G_ONE) |=> sample_i == $past(samp2_ext));
  assert_invert_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v2_i && gain2_i == G_MONE) |=> sample_i == -$past(samp2_ext));
  assert_reset_R8: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!valid_i && sample_i == '0));
endmodule

bind dds_trim dds_trim_chk #(
  .ACC_W(ACC_W), .SAMP_W(SAMP_W), .GAIN_W(GAIN_W), .FRAC(FRAC), .OUT_W(OUT_W)
) i_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i), .inc_i (phase_inc_i),
  .acc_i (acc_now), .v1_i (s1_v), .v2_i (s2_v), .samp2_i (s2_samp),
  .gain2_i (s2_gain), .valid_i (valid_o), .sample_i (sample_o)
);

// File: tb/test_dds_trim.sv
module test_dds_trim;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [31:0] phase_inc_i = '0;
  logic [31:0] phase_ofs_i = '0;
  logic [15:0] gain_i = '0;
  logic [15:0] sample_o;
  logic        valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model_phase = '0;
  int    exp_q[$];
  string tag_q[$];

  always #10 clk_i = ~clk_i;   // 50 MHz

  dds_trim i_dds_trim (
    .clk_i (clk_i), .rst_ni (rst_ni), .en_i (en_i),
    .phase_inc_i (phase_inc_i), .phase_ofs_i (phase_ofs_i), .gain_i (gain_i),
    .sample_o (sample_o), .valid_o (valid_o)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // Table value written from R3.
  function automatic int ref_table(int a);
    int h = a & 2047;
    int d = (h > 1024) ? (2048 - h) : h;
    longint w = longint'(d) * (2048 - d);
    longint f = (longint'(32752) * w) / (longint'(20971520) - 4 * w);
    return (a >= 2048) ? -int'(f) : int'(f);
  endfunction

  // Gain stage written from R4 with explicit floor division.
  function automatic int ref_gain(int t, logic [15:0] g);
    longint p = longint'(t) * longint'($signed(g));
    longint q = (p >= 0) ? (p / 16384) : -((-p + 16383) / 16384);
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return int'(q);
  endfunction

  // Output stream monitor (R6 ordering, value per R2-R4).
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R6: got unexpected valid sample %0d expected none", $signed(sample_o));
      end else begin
        check(tag_q.pop_front(), int'($signed(sample_o)), exp_q.pop_front());
      end
    end
  end

  // Launch one sample; expected value given explicitly.
  task automatic issue_exp(logic [31:0] inc, logic [31:0] ofs, logic [15:0] g, int exp, string tag);
    en_i = 1'b1; phase_inc_i = inc; phase_ofs_i = ofs; gain_i = g;
    exp_q.push_back(exp); tag_q.push_back(tag);
    model_phase = model_phase + inc;
    @(negedge clk_i);
    en_i = 1'b0;
  endtask

  // Launch one sample; expected value from the reference model.
  task automatic issue(logic [31:0] inc, logic [31:0] ofs, logic [15:0] g, string tag);
    logic [31:0] p = model_phase + ofs;
    issue_exp(inc, ofs, g, ref_gain(ref_table(int'(p[31:20])), g), tag);
  endtask

  task automatic idle(int n);
    en_i = 1'b0;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    idle(4);
    rst_ni = 1'b0;
    exp_q.delete(); tag_q.delete();
    model_phase = '0;
    @(negedge clk_i);
    check("R8 valid in reset", int'(valid_o), 0);
    check("R8 sample in reset", int'(sample_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R8 valid after release", int'(valid_o), 0);
    check("R8 sample after release", int'(sample_o), 0);
  endtask

  task automatic t_latency();
    t_reset();
    issue_exp(32'h0, 32'h4000_0000, 16'h4000, 2047, "R6 single sample");
    check("R6 valid one edge after", int'(valid_o), 0);
    @(negedge clk_i);
    check("R6 valid two edges after", int'(valid_o), 0);
    @(negedge clk_i);
    check("R6 valid three edges after", int'(valid_o), 1);
    @(negedge clk_i);
    check("R6 valid pulse ends", int'(valid_o), 0);
  endtask

  task automatic t_points();
    t_reset();
    issue_exp(32'h0, 32'h0000_0000, 16'h4000, 0,     "R3 addr 0");
    issue_exp(32'h0, 32'h4000_0000, 16'h4000, 2047,  "R3 addr 1024");
    issue_exp(32'h0, 32'h8000_0000, 16'h4000, 0,     "R3 addr 2048");
    issue_exp(32'h0, 32'hC000_0000, 16'h4000, -2047, "R3 addr 3072");
    issue_exp(32'h0, 32'h2000_0000, 16'h4000, 1444,  "R3 addr 512");
    issue_exp(32'h0, 32'h2000_0000, 16'hC000, -1444, "R5 invert addr 512");
    issue_exp(32'h0, 32'h4000_0000, 16'h8000, -4094, "R4 gain -2.0");
    issue_exp(32'h0, 32'hC000_0000, 16'h2000, -1024, "R4 floor of -1023.5");
    issue_exp(32'h0, 32'h4000_0000, 16'h7FFF, 4093,  "R4 max gain");
    issue_exp(32'h0, 32'h4000_0000, 16'h0000, 0,     "R4 zero gain");
    idle(4);
  endtask

  task automatic t_wrap();
    t_reset();
    issue_exp(32'hC000_0000, 32'h0, 16'h4000, 0,     "R1 phase 0");
    issue_exp(32'hC000_0000, 32'h0, 16'h4000, -2047, "R1 phase 3/4");
    issue_exp(32'hC000_0000, 32'h0, 16'h4000, 0,     "R1 wrapped phase 1/2");
    issue_exp(32'hC000_0000, 32'h0, 16'h4000, 2047,  "R1 wrapped phase 1/4");
    issue_exp(32'hC000_0000, 32'h0, 16'h4000, 0,     "R1 wrapped phase 0");
    idle(4);
  endtask

  task automatic t_sweep_unity();
    for (int k = 0; k < 64; k++) issue(32'h0123_4567, 32'h0, 16'h4000, "R5 unity sweep");
    idle(4);
  endtask

  task automatic t_sweep_invert();
    for (int k = 0; k < 40; k++) issue(32'h0765_4321, 32'h1000_0000, 16'hC000, "R5 inverted sweep");
    idle(4);
  endtask

  task automatic t_mixed();
    for (int k = 0; k < 48; k++) begin
      logic [31:0] ofs = 32'h3C1F_0000 * k;
      logic [15:0] g = 16'(16'h1357 * k);
      issue(32'h0040_0000 + 32'(k) * 32'h0011_0000, ofs, g, "R2 R4 per-cycle offset and gain");
    end
    idle(4);
  endtask

  task automatic t_gaps_hold();
    logic [15:0] held;
    for (int k = 0; k < 12; k++) begin
      issue(32'h0A00_0000, 32'h0, 16'h5000, "R1 gapped enables");
      idle(k % 3);
    end
    idle(4);
    held = sample_o;
    for (int k = 0; k < 6; k++) begin
      phase_inc_i = 32'hFFFF_0000; phase_ofs_i = 32'h1234_5678 * k; gain_i = 16'h8000;
      @(negedge clk_i);
      check("R7 valid stays low", int'(valid_o), 0);
      check("R7 sample holds", int'(sample_o), int'(held));
    end
    issue(32'h0, 32'h0, 16'h4000, "R1 phase kept over idle");
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_i);
    t_latency();
    t_points();
    t_wrap();
    t_reset();
    t_sweep_unity();
    t_sweep_invert();
    t_mixed();
    t_gaps_hold();
    check("R6 all launched samples delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule